// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a processor register file in which every procedure level sees its own small group of registers. The physical registers form a ring of windows. A current-window pointer chooses the active window. A call moves the pointer one window deeper, and a return moves it one window back. Each window has three regions: inbound arguments, private locals and outbound arguments. The outbound region of a window uses the same physical registers as the inbound region of the next deeper window, so a caller hands arguments to a callee without copying them. A small group of globals sits outside the ring and is reached from every window at the same physical location.

A saved-window pointer marks the boundary between resident windows and windows that have been moved out to memory. If a call would cross that boundary, the block raises a spill request and holds the call until software reports that the oldest window is saved. If a return would re-enter a window that was moved out, the block raises a fill request and holds the return until software reports the restore. Both pointers are output so that the handler can locate the window it must transfer. Two combinational read ports and one write port take logical register numbers.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 0..9 are globals, 10..15 are inbound arguments, 16..25 are locals and 26..31 are outbound arguments. Locals written in one window cannot be seen from any other window.
- R2: Outbound register 26+k of window w is the same storage as inbound register 10+k of window (w+1) mod 8. This also holds across the wrap from window 7 to window 0.
- R3: An accepted call moves the current pointer to (cwp+1) mod 8 after the clock edge, and an accepted return moves it to (cwp-1) mod 8. If call and return are strobed in the same cycle, only the call takes effect. The current pointer never equals the saved pointer.
- R4: Globals are not remapped. A global written in one window reads back the same value in every other window.
- R5: A call made while (cwp+1) mod 8 equals swp raises ovf_req from the next cycle on, and the current pointer stays where it is. ovf_req and unf_req are never high together.
- R6: While ovf_req is high, call and return strobes are ignored. A spill_done pulse advances swp by one (mod 8), completes the stalled call, and drops ovf_req after the edge.
- R7: A return made while (cwp-1) mod 8 equals swp raises unf_req and holds the return. A fill_done pulse then moves both cwp and swp back by one (mod 8) and drops unf_req.
- R8: After reset, cwp is 0, swp is 7, both requests are low and every register reads zero.
- R9: Writes to logical register 0 are discarded, and reads of register 0 return zero.
- R10: A read in the same cycle as a write to the same register returns the old value. A write is placed in the window that is active in the cycle it is presented, even when a call is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rda_addr | input | 5 | Read port A logical register number |
| rda_data | output | 32 | Read port A data (combinational) |
| rdb_addr | input | 5 | Read port B logical register number |
| rdb_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write logical register number |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| ovf_req | output | 1 | Spill request: oldest resident window must be saved |
| spill_done | input | 1 | Spill finished acknowledge |
| unf_req | output | 1 | Fill request: window being returned to must be restored |
| fill_done | input | 1 | Fill finished acknowledge |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |

## Verification
The bench builds the block with its default sizes: 8 windows of 6 inbound, 10 local and 6 outbound registers, 10 globals and 32-bit data. With only eight windows, a run of seven calls from reset reaches the first spill. One more call then wraps the ring from window 7 to window 0, so the modulo overlap and a second spill are tested within a few dozen cycles. Unwinding the same path reaches two fills in a row, and the pointers end back at their reset values.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  typedef enum logic [1:0] {
    WS_RUN   = 2'd0,
    WS_SPILL = 2'd1,
    WS_FILL  = 2'd2
  } win_state_e;

  // Physical slot of a logical register seen from window cwp.
  // Globals map straight through; windowed registers sit after them,
  // each window owning span = npar + nloc slots, with its outbound
  // region landing in the next window's inbound slots.
  function automatic int unsigned win_phys(
    input int unsigned cwp,
    input int unsigned lreg,
    input int unsigned nglb,
    input int unsigned npar,
    input int unsigned nloc,
    input int unsigned nwin
  );
    int unsigned span;
    span = npar + nloc;
    if (lreg < nglb) return lreg;
    return nglb + ((cwp * span + (lreg - nglb)) % (nwin * span));
  endfunction

  function automatic int unsigned ring_step(
    input int unsigned ptr,
    input bit          fwd,
    input int unsigned nwin
  );
    if (fwd) return (ptr + 1) % nwin;
    return (ptr + nwin - 1) % nwin;
  endfunction

endpackage

// File: rtl/winreg_ptr.sv
module winreg_ptr
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           spill_done,
  input  logic           fill_done,
  output logic [WPW-1:0] cwp,
  output logic [WPW-1:0] swp,
  output logic           ovf_req,
  output logic           unf_req,
  output logic           call_go,
  output logic           ret_go,
  output logic           spill_ack,
  output logic           fill_ack
);

  win_state_e     state_q, state_d;
  logic [WPW-1:0] cwp_fwd, cwp_bwd, swp_fwd, swp_bwd;
  logic           ring_full, ring_empty, run, ret_only;

  assign cwp_fwd = WPW'(ring_step(int'(cwp), 1'b1, NWIN));
  assign cwp_bwd = WPW'(ring_step(int'(cwp), 1'b0, NWIN));
  assign swp_fwd = WPW'(ring_step(int'(swp), 1'b1, NWIN));
  assign swp_bwd = WPW'(ring_step(int'(swp), 1'b0, NWIN));

  assign ring_full  = (cwp_fwd == swp);
  assign ring_empty = (cwp_bwd == swp);
  assign run        = (state_q == WS_RUN);
  assign ret_only   = ret_i && !call_i;

  assign call_go   = run && call_i && !ring_full;
  assign ret_go    = run && ret_only && !ring_empty;
  assign spill_ack = (state_q == WS_SPILL) && spill_done;
  assign fill_ack  = (state_q == WS_FILL) && fill_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_RUN: begin
        if (call_i && ring_full)            state_d = WS_SPILL;
        else if (ret_only && ring_empty)    state_d = WS_FILL;
      end
      WS_SPILL: if (spill_done) state_d = WS_RUN;
      WS_FILL:  if (fill_done)  state_d = WS_RUN;
      default:  state_d = WS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_RUN;
      cwp     <= '0;
      swp     <= WPW'(NWIN - 1);
    end else begin
      state_q <= state_d;
      if (call_go || spill_ack)     cwp <= cwp_fwd;
      else if (ret_go || fill_ack)  cwp <= cwp_bwd;
      if (spill_ack)                swp <= swp_fwd;
      else if (fill_ack)            swp <= swp_bwd;
    end
  end

  assign ovf_req = (state_q == WS_SPILL);
  assign unf_req = (state_q == WS_FILL);

endmodule

// File: rtl/winreg_xlat.sv
module winreg_xlat
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGLB = 10,
  parameter int NPAR = 6,
  parameter int NLOC = 10,
  parameter int AW   = 5,
  parameter int WPW  = 3,
  parameter int PW   = 8
) (
  input  logic [WPW-1:0] cwp,
  input  logic [AW-1:0]  lreg,
  output logic [PW-1:0]  phys,
  output logic           is_zero
);

  assign phys    = PW'(win_phys(int'(cwp), int'(lreg), NGLB, NPAR, NLOC, NWIN));
  assign is_zero = (lreg == '0);

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int DEPTH = 138,
  parameter int DW    = 32,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [NRD-1:0][PW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (int'(raddr[g]) < DEPTH) ? mem[raddr[g]] : '0;
  end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int NGLB = 10,
  parameter int NPAR = 6,
  parameter int NLOC = 10,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NGLB + 2 * NPAR + NLOC),
  parameter int WPW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  rda_addr,
  output logic [DW-1:0]  rda_data,
  input  logic [AW-1:0]  rdb_addr,
  output logic [DW-1:0]  rdb_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           call_i,
  input  logic           ret_i,
  output logic           ovf_req,
  input  logic           spill_done,
  output logic           unf_req,
  input  logic           fill_done,
  output logic [WPW-1:0] cwp_o,
  output logic [WPW-1:0] swp_o
);

  localparam int WSPAN = NPAR + NLOC;
  localparam int NPHYS = NGLB + NWIN * WSPAN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;

  // named internal events, observed by the bound checker
  logic call_go, ret_go, spill_ack, fill_ack;
  logic wr_kill;

  logic [NRD-1:0][AW-1:0] rd_lreg;
  logic [NRD-1:0][PW-1:0] rd_phys;
  logic [NRD-1:0]         rd_zero;
  logic [NRD-1:0][DW-1:0] rd_raw;
  logic [NRD-1:0][DW-1:0] rd_out;
  logic [PW-1:0]          wr_phys;

  winreg_ptr #(.NWIN(NWIN), .WPW(WPW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .spill_done (spill_done),
    .fill_done  (fill_done),
    .cwp        (cwp_o),
    .swp        (swp_o),
    .ovf_req    (ovf_req),
    .unf_req    (unf_req),
    .call_go    (call_go),
    .ret_go     (ret_go),
    .spill_ack  (spill_ack),
    .fill_ack   (fill_ack)
  );

  assign rd_lreg[0] = rda_addr;
  assign rd_lreg[1] = rdb_addr;

  for (genvar g = 0; g < NRD; g++) begin : g_rmap
    winreg_xlat #(
      .NWIN(NWIN), .NGLB(NGLB), .NPAR(NPAR), .NLOC(NLOC),
      .AW(AW), .WPW(WPW), .PW(PW)
    ) u_xlat (
      .cwp     (cwp_o),
      .lreg    (rd_lreg[g]),
      .phys    (rd_phys[g]),
      .is_zero (rd_zero[g])
    );
    assign rd_out[g] = rd_zero[g] ? '0 : rd_raw[g];
  end

  winreg_xlat #(
    .NWIN(NWIN), .NGLB(NGLB), .NPAR(NPAR), .NLOC(NLOC),
    .AW(AW), .WPW(WPW), .PW(PW)
  ) u_wmap (
    .cwp     (cwp_o),
    .lreg    (wr_addr),
    .phys    (wr_phys),
    .is_zero (wr_kill)
  );

  winreg_bank #(.DEPTH(NPHYS), .DW(DW), .PW(PW), .NRD(NRD)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && !wr_kill),
    .waddr (wr_phys),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rdata (rd_raw)
  );

  assign rda_data = rd_out[0];
  assign rdb_data = rd_out[1];

endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int NWIN = 8,
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int WPW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           call_i,
  input logic           ret_i,
  input logic           spill_done,
  input logic           fill_done,
  input logic           ovf_req,
  input logic           unf_req,
  input logic [WPW-1:0] cwp_o,
  input logic [WPW-1:0] swp_o,
  input logic [AW-1:0]  rda_addr,
  input logic [DW-1:0]  rda_data,
  input logic           call_go,
  input logic           ret_go
);

  logic [WPW-1:0] nxt, prv;
  assign nxt = WPW'((int'(cwp_o) + 1) % NWIN);
  assign prv = WPW'((int'(cwp_o) + NWIN - 1) % NWIN);

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |=> cwp_o == WPW'((int'($past(cwp_o)) + 1) % NWIN)); // R3
  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> cwp_o == WPW'((int'($past(cwp_o)) + NWIN - 1) % NWIN)); // R3
  AST_PTR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_o != swp_o); // R3
  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ovf_req && !unf_req && nxt == swp_o) |=> (ovf_req && $stable(cwp_o))); // R5
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_req && unf_req)); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_req && !spill_done) |=> (ovf_req && $stable(cwp_o) && $stable(swp_o))); // R6
  AST_SPILL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_req && spill_done) |=> (!ovf_req && swp_o == WPW'((int'($past(swp_o)) + 1) % NWIN))); // R6
  AST_UNF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !ovf_req && !unf_req && prv == swp_o) |=> (unf_req && $stable(cwp_o))); // R7
  AST_FILL_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_req && fill_done) |=> (!unf_req && swp_o == WPW'((int'($past(swp_o)) + NWIN - 1) % NWIN))); // R7
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_addr == '0) |-> (rda_data == '0)); // R9

endmodule

bind winreg_file winreg_chk #(.NWIN(NWIN), .AW(AW), .DW(DW), .WPW(WPW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .spill_done (spill_done),
  .fill_done  (fill_done),
  .ovf_req    (ovf_req),
  .unf_req    (unf_req),
  .cwp_o      (cwp_o),
  .swp_o      (swp_o),
  .rda_addr   (rda_addr),
  .rda_data   (rda_data),
  .call_go    (call_go),
  .ret_go     (ret_go)
);

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rda_addr = '0, rdb_addr = '0, wr_addr = '0;
  logic [31:0] rda_data, rdb_data, wr_data = '0;
  logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic        spill_done = 1'b0, fill_done = 1'b0;
  logic        ovf_req, unf_req;
  logic [2:0]  cwp_o, swp_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  winreg_file dut (
    .clk(clk), .rst_n(rst_n),
    .rda_addr(rda_addr), .rda_data(rda_data),
    .rdb_addr(rdb_addr), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i),
    .ovf_req(ovf_req), .spill_done(spill_done),
    .unf_req(unf_req), .fill_done(fill_done),
    .cwp_o(cwp_o), .swp_o(swp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs set before the rising edge, result sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; call_i = 0; ret_i = 0; spill_done = 0; fill_done = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    rda_addr = a; rdb_addr = a; #1;
    chk(req, rda_data, exp);
    chk(req, rdb_data, exp);
  endtask

  task automatic call1(); call_i = 1; step(); endtask
  task automatic ret1();  ret_i = 1;  step(); endtask

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read, 2 call, 3 return
    logic [4:0]  reg_n;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'd5,  32'h0000_0055},  // R4 global
    '{2'd0, 5'd16, 32'h0000_1600},  // R1 local w0
    '{2'd0, 5'd26, 32'h0000_00A0},  // R2 outbound w0
    '{2'd1, 5'd26, 32'h0000_00A0},
    '{2'd2, 5'd0,  32'h0},
    '{2'd1, 5'd10, 32'h0000_00A0},  // R2 inbound w1
    '{2'd1, 5'd16, 32'h0},          // R1 fresh local w1
    '{2'd1, 5'd5,  32'h0000_0055},  // R4
    '{2'd0, 5'd16, 32'h0000_1611},
    '{2'd0, 5'd0,  32'hDEAD_BEEF},  // R9
    '{2'd1, 5'd0,  32'h0},          // R9
    '{2'd3, 5'd0,  32'h0},
    '{2'd1, 5'd16, 32'h0000_1600},  // R1
    '{2'd1, 5'd26, 32'h0000_00A0},  // R2
    '{2'd1, 5'd10, 32'h0}           // R1 inbound w0 untouched
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    chk("R8 cwp", 32'(cwp_o), 32'd0);
    chk("R8 swp", 32'(swp_o), 32'd7);
    chk("R8 req", {30'd0, ovf_req, unf_req}, 32'd0);
    rd("R8 reg", 5'd20, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].reg_n, VEC[i].val);
        2'd1: rd($sformatf("R1/R2/R4/R9 vec%0d", i), VEC[i].reg_n, VEC[i].val);
        2'd2: call1();
        default: ret1();
      endcase
    end
    chk("R3 table end cwp", 32'(cwp_o), 32'd0);

    // R3 calls up to the ring limit
    for (int i = 0; i < 6; i++) call1();
    chk("R3 cwp after 6 calls", 32'(cwp_o), 32'd6);
    chk("R5 no ovf yet", 32'(ovf_req), 32'd0);

    // R5 overflow
    call1();
    chk("R5 ovf raised", 32'(ovf_req), 32'd1);
    chk("R5 cwp held", 32'(cwp_o), 32'd6);
    call_i = 1; step();
    ret_i = 1; step();
    chk("R6 strobes ignored cwp", 32'(cwp_o), 32'd6);
    chk("R6 still waiting", 32'(ovf_req), 32'd1);
    spill_done = 1; step();
    chk("R6 cwp after spill", 32'(cwp_o), 32'd7);
    chk("R6 swp after spill", 32'(swp_o), 32'd0);
    chk("R6 ovf dropped", 32'(ovf_req), 32'd0);

    // R2 wrap from window 7 into window 0
    wr(5'd26, 32'h0000_0077);
    call1();
    chk("R5 second ovf", 32'(ovf_req), 32'd1);
    spill_done = 1; step();
    chk("R6 wrap cwp", 32'(cwp_o), 32'd0);
    chk("R6 wrap swp", 32'(swp_o), 32'd1);
    rd("R2 wrap inbound", 5'd10, 32'h0000_0077);

    // R7 unwind
    for (int i = 0; i < 6; i++) ret1();
    chk("R3 cwp after returns", 32'(cwp_o), 32'd2);
    chk("R7 no unf yet", 32'(unf_req), 32'd0);
    ret1();
    chk("R7 unf raised", 32'(unf_req), 32'd1);
    chk("R7 cwp held", 32'(cwp_o), 32'd2);
    fill_done = 1; step();
    chk("R7 cwp after fill", 32'(cwp_o), 32'd1);
    chk("R7 swp after fill", 32'(swp_o), 32'd0);
    chk("R7 unf dropped", 32'(unf_req), 32'd0);
    ret1();
    chk("R7 unf again", 32'(unf_req), 32'd1);
    fill_done = 1; step();
    chk("R7 cwp home", 32'(cwp_o), 32'd0);
    chk("R7 swp home", 32'(swp_o), 32'd7);

    // R3 call and return together: call wins
    call_i = 1; ret_i = 1; step();
    chk("R3 both strobes", 32'(cwp_o), 32'd1);
    ret1();
    chk("R3 back to 0", 32'(cwp_o), 32'd0);

    // R10 read during write
    wr_en = 1; wr_addr = 5'd20; wr_data = 32'h0000_BEEF;
    rda_addr = 5'd20; rdb_addr = 5'd20; #1;
    chk("R10 old value", rda_data, 32'h0);
    step();
    rd("R10 new value", 5'd20, 32'h0000_BEEF);

    // R10 write with call in same cycle lands in old window
    wr_en = 1; wr_addr = 5'd17; wr_data = 32'h0000_1234; call_i = 1; step();
    chk("R10 call taken", 32'(cwp_o), 32'd1);
    rd("R10 not in new window", 5'd17, 32'h0);
    ret1();
    rd("R10 in old window", 5'd17, 32'h0000_1234);

    // R9 zero register from another window
    call1();
    wr(5'd0, 32'hFFFF_FFFF);
    rd("R9 zero reg", 5'd0, 32'h0);
    rd("R4 global seen", 5'd5, 32'h0000_0055);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule